// File: doc/BRIEF.md
# Memory Region Domain Access Checker

This block decides whether a memory access may proceed. A request carries an address, the ID of the domain that issued it, a read/write flag and two attributes (privileged and secure). The block compares the request against a small bank of region descriptors. Each descriptor holds an inclusive address window with 4 KB granularity, a 3-bit access policy for each of 16 domains, and a lock mode. One clock cycle later it returns a single allow bit. When the global enable input is low, the checker is bypassed and every request is allowed.

Descriptors are programmed through a word-wide configuration port. Each descriptor has four words: start, end, low policies and high policies. Each descriptor runs a three-state machine:

- `SLOT_EMPTY`: the state after reset. The descriptor never matches.
- `SLOT_OPEN`: the descriptor is valid and can still be rewritten.
- `SLOT_LOCKED`: the descriptor is valid and frozen until reset.

Only a write of the high-policy word moves a descriptor between states. Transition ARM goes from `SLOT_EMPTY` to `SLOT_OPEN` when the written lock field is zero. Transition REARM keeps a descriptor in `SLOT_OPEN` when a zero lock is written again. Transition SEAL goes from `SLOT_EMPTY` or `SLOT_OPEN` to `SLOT_LOCKED` when the written lock field is nonzero. `SLOT_LOCKED` has no exit except reset.

Top module: `rdc_region_checker`

## Requirements
- R1: After reset, every descriptor is in `SLOT_EMPTY`, `resp_valid` is low, and a lookup made while `gbl_en` is high is denied.
- R2: A descriptor matches when the address bits [31:12] lie between the stored start and end page numbers, both inclusive. The end page covers its whole 4 KB, through offset 0xFFF. Bits [11:0] of written start and end words are ignored.
- R3: In the low-policy word (`cfg_sel`=2), domain d (0 to 7) uses bits [3d+2:3d]. In the high-policy word (`cfg_sel`=3), domain d (8 to 15) uses bits [3(d-8)+2:3(d-8)]. `cfg_sel`=0 writes the start and `cfg_sel`=1 writes the end.
- R4: The policy encoding is as follows. "rw" means both reads and writes are allowed.
  - 0: deny all.
  - 1: rw only when both secure and privileged.
  - 2: rw when secure.
  - 3: as 2, plus privileged non-secure reads.
  - 4: as 2, plus all non-secure reads.
  - 5: as 2, plus privileged non-secure rw.
  - 6: all rw.
  - 7: reads only.
- R5: Only a write of the high-policy word makes a descriptor valid. The lock mode is taken from bits [29:28] of that word. Start, end or low-policy writes alone leave an empty descriptor non-matching.
- R6: Once a nonzero lock mode has been written, writes to all four words of that descriptor are ignored until reset. Reset makes it writable again.
- R7: A descriptor in `SLOT_EMPTY` never matches. An address that no valid descriptor covers is denied.
- R8: When several valid descriptors match, the access is allowed if any one of them permits it.
- R9: While `gbl_en` is low, every request is allowed.
- R10: `resp_valid` is high exactly one cycle after `req_valid`. `resp_allow` is low whenever `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gbl_en | input | 1 | Checker enable; low allows all requests |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_idx | input | 2 | Descriptor index |
| cfg_sel | input | 2 | Word select: 0 start, 1 end, 2 low policies, 3 high policies and lock |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Request address |
| req_dom | input | 4 | Requesting domain ID |
| req_write | input | 1 | 1 for write, 0 for read |
| req_priv | input | 1 | Privileged attribute |
| req_secure | input | 1 | Secure attribute |
| resp_valid | output | 1 | Decision valid, one cycle after a request |
| resp_allow | output | 1 | Access permitted |

## Verification
The lookups probe addresses exactly at the first and last byte of a window, and one byte outside it. This separates inclusive from exclusive bounds and exposes a lost end-page offset. Every policy code is tried with the attribute combinations that split it from its neighbours, such as privileged versus plain non-secure reads, and secure writes versus non-secure writes. Domains on both sides of the word split (0 to 7 versus 8 to 15) show whether the high word is unpacked. Overlapping windows with conflicting policies separate OR-merging from first-match. Rewrites aimed at a sealed descriptor, followed by a reset, show that the lock is both sticky and cleared by reset.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    localparam int ADDR_W       = 32;
    localparam int DATA_W       = 32;
    localparam int PAGE_BITS    = 12;
    localparam int PAGE_W       = ADDR_W - PAGE_BITS;
    localparam int NUM_DOM      = 16;
    localparam int DOM_W        = $clog2(NUM_DOM);
    localparam int POL_W        = 3;
    localparam int DOM_PER_WORD = NUM_DOM / 2;
    localparam int LOCK_LSB     = 28;
    localparam int LOCK_W       = 2;

    localparam logic [1:0] SEL_START  = 2'd0;
    localparam logic [1:0] SEL_END    = 2'd1;
    localparam logic [1:0] SEL_POL_LO = 2'd2;
    localparam logic [1:0] SEL_POL_HI = 2'd3;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_OPEN   = 2'd1,
        SLOT_LOCKED = 2'd2
    } slot_state_e;

    function automatic logic policy_ok(input logic [POL_W-1:0] pol,
                                       input logic wr,
                                       input logic priv,
                                       input logic sec);
        logic ok;
        case (pol)
            3'd0:    ok = 1'b0;
            3'd1:    ok = sec & priv;
            3'd2:    ok = sec;
            3'd3:    ok = sec | (priv & ~wr);
            3'd4:    ok = sec | ~wr;
            3'd5:    ok = sec | priv;
            3'd6:    ok = 1'b1;
            default: ok = ~wr;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/rdc_desc_slot.sv
module rdc_desc_slot
    import rdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] look_addr,
    input  logic [DOM_W-1:0]  look_dom,
    input  logic              look_write,
    input  logic              look_priv,
    input  logic              look_sec,
    output logic              permit
);
    slot_state_e st_q, st_d;
    logic [PAGE_W-1:0]           start_q, end_q;
    logic [NUM_DOM-1:0][POL_W-1:0] pol_q;
    logic                        writable, seal_req, arm_req;
    logic [PAGE_W-1:0]           addr_pg;
    logic                        in_window;
    logic                        unused_low;

    assign writable = (st_q != SLOT_LOCKED);
    assign arm_req  = wr_en && writable && (wr_sel == SEL_POL_HI);
    assign seal_req = arm_req && (wr_data[LOCK_LSB +: LOCK_W] != '0);

    // next-state: ARM, REARM, SEAL
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY, SLOT_OPEN: begin
                if (seal_req)     st_d = SLOT_LOCKED;
                else if (arm_req) st_d = SLOT_OPEN;
            end
            SLOT_LOCKED: st_d = SLOT_LOCKED;
            default:     st_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '1;
            pol_q   <= '0;
        end else if (wr_en && writable) begin
            unique case (wr_sel)
                SEL_START: start_q <= wr_data[ADDR_W-1:PAGE_BITS];
                SEL_END:   end_q   <= wr_data[ADDR_W-1:PAGE_BITS];
                SEL_POL_LO:
                    for (int d = 0; d < DOM_PER_WORD; d++)
                        pol_q[d] <= wr_data[POL_W*d +: POL_W];
                default:
                    for (int d = 0; d < DOM_PER_WORD; d++)
                        pol_q[d+DOM_PER_WORD] <= wr_data[POL_W*d +: POL_W];
            endcase
        end
    end

    // output process
    assign addr_pg    = look_addr[ADDR_W-1:PAGE_BITS];
    assign unused_low = ^look_addr[PAGE_BITS-1:0];

    always_comb begin
        in_window = (addr_pg >= start_q) && (addr_pg <= end_q);
        permit    = (st_q != SLOT_EMPTY) && in_window &&
                    policy_ok(pol_q[look_dom], look_write, look_priv, look_sec);
    end

    assert_locked_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_LOCKED) |=> (st_q == SLOT_LOCKED));
    assert_locked_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_LOCKED) |=> ($stable(start_q) && $stable(end_q) && $stable(pol_q)));
    assert_high_word_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_POL_HI && st_q != SLOT_LOCKED) |=> (st_q != SLOT_EMPTY));
    assert_other_words_keep_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_EMPTY && !(wr_en && wr_sel == SEL_POL_HI)) |=> (st_q == SLOT_EMPTY));
    assert_empty_denies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SLOT_EMPTY) |-> !permit);
endmodule

// File: rtl/rdc_verdict_reg.sv
module rdc_verdict_reg #(
    parameter int NUM_RGN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gbl_en,
    input  logic               req_valid,
    input  logic [NUM_RGN-1:0] permit,
    output logic               resp_valid,
    output logic               resp_allow
);
    logic any_permit;
    assign any_permit = |permit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= req_valid;
            resp_allow <= req_valid && (!gbl_en || any_permit);
        end
    end

    assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_allow_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_allow |-> resp_valid);
    assert_bypass_allows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !gbl_en) |=> resp_allow);
    assert_no_hit_denies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gbl_en && permit == '0) |=> !resp_allow);
endmodule

// File: rtl/rdc_region_checker.sv
module rdc_region_checker
    import rdc_pkg::*;
#(
    parameter int NUM_RGN = 4,
    localparam int IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gbl_en,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DOM_W-1:0]  req_dom,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              req_secure,
    output logic              resp_valid,
    output logic              resp_allow
);
    logic [NUM_RGN-1:0] slot_permit;

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_slot
        logic slot_we;
        assign slot_we = cfg_we && (cfg_idx == IDX_W'(r));

        rdc_desc_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (slot_we),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .look_addr  (req_addr),
            .look_dom   (req_dom),
            .look_write (req_write),
            .look_priv  (req_priv),
            .look_sec   (req_secure),
            .permit     (slot_permit[r])
        );
    end

    rdc_verdict_reg #(.NUM_RGN(NUM_RGN)) u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .gbl_en     (gbl_en),
        .req_valid  (req_valid),
        .permit     (slot_permit),
        .resp_valid (resp_valid),
        .resp_allow (resp_allow)
    );
endmodule

// File: tb/tb_rdc_region_checker.sv
`timescale 1ns/1ps
module tb_rdc_region_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gbl_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_dom = '0;
    logic        req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
    logic        resp_valid, resp_allow;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rdc_region_checker dut (
        .clk(clk), .rst_n(rst_n), .gbl_en(gbl_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_dom(req_dom),
        .req_write(req_write), .req_priv(req_priv), .req_secure(req_secure),
        .resp_valid(resp_valid), .resp_allow(resp_allow)
    );

    // {tag, addr, dom, write, priv, secure, expected}
    localparam int NV = 26;
    localparam logic [43:0] VEC [NV] = '{
        {4'd2, 32'h0000_1000, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1}, // R2 first byte
        {4'd7, 32'h0000_0FFF, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0}, // R7 below all
        {4'd2, 32'h0000_2FFF, 4'd0,  1'b1, 1'b0, 1'b0, 1'b1}, // R2 end page offset FFF
        {4'd4, 32'h0000_1800, 4'd1,  1'b0, 1'b0, 1'b0, 1'b1}, // R4 code 7 read
        {4'd4, 32'h0000_1800, 4'd1,  1'b1, 1'b0, 1'b0, 1'b0}, // R4 code 7 write
        {4'd8, 32'h0000_2800, 4'd1,  1'b1, 1'b0, 1'b0, 1'b1}, // R8 overlap grants
        {4'd4, 32'h0000_1800, 4'd2,  1'b1, 1'b1, 1'b1, 1'b1}, // R4 code 1
        {4'd4, 32'h0000_1800, 4'd2,  1'b1, 1'b0, 1'b1, 1'b0},
        {4'd4, 32'h0000_1800, 4'd3,  1'b1, 1'b0, 1'b1, 1'b1}, // R4 code 2
        {4'd4, 32'h0000_1800, 4'd3,  1'b0, 1'b0, 1'b0, 1'b0},
        {4'd4, 32'h0000_1800, 4'd4,  1'b0, 1'b1, 1'b0, 1'b1}, // R4 code 3
        {4'd4, 32'h0000_1800, 4'd4,  1'b0, 1'b0, 1'b0, 1'b0},
        {4'd4, 32'h0000_1800, 4'd4,  1'b1, 1'b1, 1'b0, 1'b0},
        {4'd4, 32'h0000_1800, 4'd5,  1'b0, 1'b0, 1'b0, 1'b1}, // R4 code 4
        {4'd4, 32'h0000_1800, 4'd5,  1'b1, 1'b1, 1'b0, 1'b0},
        {4'd4, 32'h0000_1800, 4'd6,  1'b1, 1'b1, 1'b0, 1'b1}, // R4 code 5
        {4'd4, 32'h0000_1800, 4'd6,  1'b1, 1'b0, 1'b0, 1'b0},
        {4'd4, 32'h0000_1800, 4'd7,  1'b0, 1'b1, 1'b1, 1'b0}, // R4 code 0
        {4'd3, 32'h0000_1800, 4'd8,  1'b1, 1'b0, 1'b0, 1'b1}, // R3 high word low slot
        {4'd3, 32'h0000_1800, 4'd15, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 high word top slot
        {4'd3, 32'h0000_1800, 4'd15, 1'b1, 1'b0, 1'b0, 1'b0},
        {4'd6, 32'h0000_1800, 4'd9,  1'b0, 1'b0, 1'b0, 1'b0}, // R6 start rewrite ignored
        {4'd6, 32'h0000_3800, 4'd9,  1'b0, 1'b0, 1'b0, 1'b1}, // R6 locked still valid
        {4'd6, 32'h0000_3800, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0}, // R6 policy rewrite ignored
        {4'd2, 32'h0000_5000, 4'd1,  1'b1, 1'b0, 1'b0, 1'b0}, // R2 one past end
        {4'd2, 32'h0000_4FFF, 4'd1,  1'b1, 1'b0, 1'b0, 1'b1}  // R2 last byte
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] a, input logic [3:0] dm, input logic w,
                          input logic p, input logic s, input logic exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_dom = dm;
        req_write = w; req_priv = p; req_secure = s;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "resp_valid after request", resp_valid, 1'b1);
        check(req, $sformatf("allow addr=%h dom=%0d", a, dm), resp_allow, exp);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo0;
        lo0 = 32'd6 | (32'd7 << 3) | (32'd1 << 6) | (32'd2 << 9) |
              (32'd3 << 12) | (32'd4 << 15) | (32'd5 << 18);
        repeat (3) @(negedge clk);
        check("R1", "resp_valid in reset", resp_valid, 1'b0);
        rst_n = 1'b1;
        lookup(32'h0000_1000, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R1");

        // region 0: page-offset garbage in bounds (R2)
        cfg_write(2'd0, 2'd0, 32'h0000_1ABC);
        cfg_write(2'd0, 2'd1, 32'h0000_2123);
        cfg_write(2'd0, 2'd2, lo0);
        lookup(32'h0000_1000, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        cfg_write(2'd0, 2'd3, 32'h00E0_0006);
        lookup(32'h0000_1000, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R5");

        // region 1: sealed with lock 01, then rewrite attempts
        cfg_write(2'd1, 2'd0, 32'h0000_3000);
        cfg_write(2'd1, 2'd1, 32'h0000_3FFF);
        cfg_write(2'd1, 2'd2, 32'h0000_0000);
        cfg_write(2'd1, 2'd3, 32'h1000_0030);
        cfg_write(2'd1, 2'd0, 32'h0000_0000);
        cfg_write(2'd1, 2'd2, 32'h0000_0006);
        cfg_write(2'd1, 2'd3, 32'h0000_0036);

        // region 2: overlaps region 0 and region 1
        cfg_write(2'd2, 2'd0, 32'h0000_2000);
        cfg_write(2'd2, 2'd1, 32'h0000_4FFF);
        cfg_write(2'd2, 2'd2, 32'h0000_0030);
        cfg_write(2'd2, 2'd3, 32'h0000_0000);

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            lookup(v[39:8], v[7:4], v[3], v[2], v[1], v[0], tag_name(v[43:40]));
        end

        // R7: region 3 empty although its default window spans all
        lookup(32'h8000_0000, 4'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R7");

        // R9: global bypass
        gbl_en = 1'b0;
        lookup(32'h8000_0000, 4'd7, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        gbl_en = 1'b1;

        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10", "resp_valid idle", resp_valid, 1'b0);
        check("R10", "resp_allow idle", resp_allow, 1'b0);

        // R6: reset clears the lock; region 1 rewritable
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lookup(32'h0000_1000, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
        cfg_write(2'd1, 2'd0, 32'h0000_3000);
        cfg_write(2'd1, 2'd1, 32'h0000_3FFF);
        cfg_write(2'd1, 2'd2, 32'h0000_0006);
        cfg_write(2'd1, 2'd3, 32'h0000_0000);
        lookup(32'h0000_3800, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule